// File: doc/BRIEF.md
# Reorder Buffer with In-Order Retirement

This block tracks speculatively executed instructions in program order inside a circular buffer of eight entries. When the dispatch stage offers an instruction and a reservation station is free, the block allocates the next slot. The slot records the instruction class, the destination register and a not-yet-done status. The slot index is returned as the instruction's tag, and the tag travels with the operation through execution.

Finished results arrive on a broadcast bus addressed by tag. They land in their slot together with an exception flag and, for branches, a misprediction flag and the correct target. A rename map holds, for each architectural register, the tag of the youngest in-flight writer. An operand lookup port reports that mapping together with the slot's value once it is done. At most one slot leaves the oldest end of the buffer per cycle. Retiring a slot writes the register file, releases a store's data to memory, or raises a held exception. A mispredicted branch at the oldest end pulses a flush with the redirect address, and the flush discards every younger slot and clears the map.

Top module: `rob_core`

## Requirements
- R1: An instruction is accepted (`disp_fire_o` high) only when `disp_valid_i` and `disp_rs_free_i` are high, the buffer is not full and no flush is happening. Accepted instructions receive tags 0,1,2,... in order, wrapping after 7.
- R2: With eight slots occupied, further dispatch is refused until a slot retires.
- R3: A bus result (`res_valid_i`, tag) marks that slot done and stores its value. A lookup of a register mapped to that slot then shows `lk_ready_o` high and that value.
- R4: Slots retire strictly oldest first, at most one per cycle. A done slot behind a pending one produces no retirement output.
- R5: Class encoding: 0 = ALU, 1 = store, 2 = branch, 3 = retires without effect. A retiring ALU slot with a destination drives `rf_we_o` with its register and value for one cycle. The register file is never written at any other time.
- R6: A retiring store drives `st_we_o` with its stored value and does not write the register file.
- R7: A slot whose result carried the exception flag raises `exc_o` and `flush_o` when it retires, writes nothing, and discards all younger slots.
- R8: A retiring branch flagged as mispredicted pulses `flush_o` for one cycle with `redirect_pc_o` equal to the target it delivered. All younger slots are discarded and all mappings are cleared. A correctly predicted branch retires with no output.
- R9: The rename map points each register at its youngest writer. Retiring an older writer of the same register leaves the mapping intact, and the mapping clears when the mapped writer retires.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| disp_valid_i | input | 1 | Dispatch request |
| disp_rs_free_i | input | 1 | A reservation station is free |
| disp_kind_i | input | 2 | Instruction class |
| disp_dst_i | input | 4 | Destination register |
| disp_wr_i | input | 1 | Instruction writes its destination |
| disp_fire_o | output | 1 | Dispatch accepted |
| disp_tag_o | output | 3 | Tag given to the accepted instruction |
| res_valid_i | input | 1 | Result bus valid |
| res_tag_i | input | 3 | Result tag |
| res_value_i | input | 32 | Result value or store data |
| res_exc_i | input | 1 | Result raised an exception |
| res_mispred_i | input | 1 | Branch was mispredicted |
| res_target_i | input | 32 | Correct branch target |
| lk_reg_i | input | 4 | Register to look up |
| lk_busy_o | output | 1 | Register has an in-flight writer |
| lk_ready_o | output | 1 | That writer's value is available |
| lk_tag_o | output | 3 | Tag of the youngest writer |
| lk_value_o | output | 32 | Value held by that slot |
| rf_we_o | output | 1 | Register file write at retirement |
| rf_addr_o | output | 4 | Register written |
| rf_data_o | output | 32 | Value written |
| st_we_o | output | 1 | Store released to memory |
| st_data_o | output | 32 | Store data |
| exc_o | output | 1 | Exception raised at retirement |
| flush_o | output | 1 | Discard all in-flight state |
| redirect_pc_o | output | 32 | Restart address during a flush |

## Verification
The assertions assume the bus only returns a result for a tag that is allocated and not yet done. Results are never replayed after a flush, and the execution side never reports a tag twice. The stimulus returns exactly one result per live tag and sends no results after a flush has emptied the buffer. It also deliberately returns results out of order, so that the oldest slot is often the last to finish.

// File: rtl/rob_pkg.sv
package rob_pkg;
  typedef enum logic [1:0] {
    KIND_ALU    = 2'd0,
    KIND_STORE  = 2'd1,
    KIND_BRANCH = 2'd2,
    KIND_NOP    = 2'd3
  } kind_e;
endpackage

// File: rtl/rob_ptr_ctrl.sv
module rob_ptr_ctrl #(
  parameter int DEPTH = 8,
  localparam int TAG_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic             pop_i,
  input  logic             flush_i,
  output logic [TAG_W-1:0] head_o,
  output logic [TAG_W-1:0] tail_o,
  output logic             full_o,
  output logic             empty_o
);
  logic [CNT_W-1:0] cnt_q;

  function automatic logic [TAG_W-1:0] nxt(input logic [TAG_W-1:0] p);
    return (p == TAG_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      head_o <= '0;
      tail_o <= '0;
      cnt_q  <= '0;
    end else if (flush_i) begin
      head_o <= '0;
      tail_o <= '0;
      cnt_q  <= '0;
    end else begin
      if (push_i) tail_o <= nxt(tail_o);
      if (pop_i)  head_o <= nxt(head_o);
      if (push_i && !pop_i)      cnt_q <= cnt_q + 1'b1;
      else if (!push_i && pop_i) cnt_q <= cnt_q - 1'b1;
    end
  end

  assign full_o  = (cnt_q == CNT_W'(DEPTH));
  assign empty_o = (cnt_q == '0);

  assert_no_overflow_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> !full_o);
  assert_no_underflow_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> !empty_o);
  assert_pop_advances_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && !flush_i) |=> head_o == nxt($past(head_o)));
  assert_flush_empties_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> empty_o);
endmodule

// File: rtl/rob_rename_map.sv
module rob_rename_map #(
  parameter int NREG  = 16,
  parameter int DEPTH = 8,
  localparam int REG_W = $clog2(NREG),
  localparam int TAG_W = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flush_i,
  input  logic             set_i,
  input  logic [REG_W-1:0] set_reg_i,
  input  logic [TAG_W-1:0] set_tag_i,
  input  logic             clr_i,
  input  logic [REG_W-1:0] clr_reg_i,
  input  logic [TAG_W-1:0] clr_tag_i,
  input  logic [REG_W-1:0] lk_reg_i,
  output logic             lk_busy_o,
  output logic [TAG_W-1:0] lk_tag_o
);
  logic [NREG-1:0]  vld_q;
  logic [TAG_W-1:0] tag_q [NREG];

  for (genvar r = 0; r < NREG; r++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        vld_q[r] <= 1'b0;
        tag_q[r] <= '0;
      end else if (flush_i) begin
        vld_q[r] <= 1'b0;
      end else if (set_i && set_reg_i == REG_W'(r)) begin
        vld_q[r] <= 1'b1;
        tag_q[r] <= set_tag_i;
      end else if (clr_i && clr_reg_i == REG_W'(r) && tag_q[r] == clr_tag_i) begin
        vld_q[r] <= 1'b0; // only the mapped writer may clear
      end
    end
  end

  assign lk_busy_o = vld_q[lk_reg_i];
  assign lk_tag_o  = tag_q[lk_reg_i];

  assert_map_youngest_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i && !flush_i) |=> vld_q[$past(set_reg_i)] && tag_q[$past(set_reg_i)] == $past(set_tag_i));
  assert_flush_clears_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> vld_q == '0);
endmodule

// File: rtl/rob_core.sv
module rob_core
  import rob_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int NREG   = 16,
  parameter int DATA_W = 32,
  parameter int PC_W   = 32,
  localparam int TAG_W = $clog2(DEPTH),
  localparam int REG_W = $clog2(NREG)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              disp_valid_i,
  input  logic              disp_rs_free_i,
  input  logic [1:0]        disp_kind_i,
  input  logic [REG_W-1:0]  disp_dst_i,
  input  logic              disp_wr_i,
  output logic              disp_fire_o,
  output logic [TAG_W-1:0]  disp_tag_o,
  input  logic              res_valid_i,
  input  logic [TAG_W-1:0]  res_tag_i,
  input  logic [DATA_W-1:0] res_value_i,
  input  logic              res_exc_i,
  input  logic              res_mispred_i,
  input  logic [PC_W-1:0]   res_target_i,
  input  logic [REG_W-1:0]  lk_reg_i,
  output logic              lk_busy_o,
  output logic              lk_ready_o,
  output logic [TAG_W-1:0]  lk_tag_o,
  output logic [DATA_W-1:0] lk_value_o,
  output logic              rf_we_o,
  output logic [REG_W-1:0]  rf_addr_o,
  output logic [DATA_W-1:0] rf_data_o,
  output logic              st_we_o,
  output logic [DATA_W-1:0] st_data_o,
  output logic              exc_o,
  output logic              flush_o,
  output logic [PC_W-1:0]   redirect_pc_o
);
  logic [DEPTH-1:0]  busy_q, done_q, wr_q, exc_q, mis_q;
  kind_e             kind_q [DEPTH];
  logic [REG_W-1:0]  dst_q  [DEPTH];
  logic [DATA_W-1:0] val_q  [DEPTH];
  logic [PC_W-1:0]   tgt_q  [DEPTH];

  logic [TAG_W-1:0] head, tail;
  logic full, empty, push, pop, head_done, head_ok;

  rob_ptr_ctrl #(.DEPTH(DEPTH)) u_ptr (
    .clk_i, .rst_ni,
    .push_i(push), .pop_i(pop), .flush_i(flush_o),
    .head_o(head), .tail_o(tail), .full_o(full), .empty_o(empty)
  );

  assign head_done = busy_q[head] && done_q[head];
  assign head_ok   = head_done && !exc_q[head];
  assign exc_o     = head_done && exc_q[head];
  assign flush_o   = exc_o || (head_ok && kind_q[head] == KIND_BRANCH && mis_q[head]);
  assign pop       = head_done;
  assign rf_we_o   = head_ok && kind_q[head] == KIND_ALU && wr_q[head];
  assign rf_addr_o = dst_q[head];
  assign rf_data_o = val_q[head];
  assign st_we_o   = head_ok && kind_q[head] == KIND_STORE;
  assign st_data_o = val_q[head];
  assign redirect_pc_o = tgt_q[head];

  assign push        = disp_valid_i && disp_rs_free_i && !full && !flush_o;
  assign disp_fire_o = push;
  assign disp_tag_o  = tail;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= '0; done_q <= '0; wr_q <= '0; exc_q <= '0; mis_q <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        kind_q[i] <= KIND_NOP;
        dst_q[i]  <= '0;
        val_q[i]  <= '0;
        tgt_q[i]  <= '0;
      end
    end else if (flush_o) begin
      busy_q <= '0;
    end else begin
      if (pop) busy_q[head] <= 1'b0;
      if (push) begin
        busy_q[tail] <= 1'b1;
        done_q[tail] <= 1'b0;
        kind_q[tail] <= kind_e'(disp_kind_i);
        dst_q[tail]  <= disp_dst_i;
        wr_q[tail]   <= disp_wr_i;
        exc_q[tail]  <= 1'b0;
        mis_q[tail]  <= 1'b0;
      end
      if (res_valid_i && busy_q[res_tag_i] && !done_q[res_tag_i]) begin
        done_q[res_tag_i] <= 1'b1;
        val_q[res_tag_i]  <= res_value_i;
        exc_q[res_tag_i]  <= res_exc_i;
        mis_q[res_tag_i]  <= res_mispred_i;
        tgt_q[res_tag_i]  <= res_target_i;
      end
    end
  end

  rob_rename_map #(.NREG(NREG), .DEPTH(DEPTH)) u_map (
    .clk_i, .rst_ni,
    .flush_i(flush_o),
    .set_i(push && disp_wr_i && kind_e'(disp_kind_i) == KIND_ALU),
    .set_reg_i(disp_dst_i), .set_tag_i(tail),
    .clr_i(rf_we_o), .clr_reg_i(dst_q[head]), .clr_tag_i(head),
    .lk_reg_i, .lk_busy_o, .lk_tag_o
  );

  assign lk_ready_o = lk_busy_o && done_q[lk_tag_o];
  assign lk_value_o = val_q[lk_tag_o];

  assert_one_retire_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({rf_we_o, st_we_o, flush_o}));
  assert_result_live_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_i |-> (busy_q[res_tag_i] && !done_q[res_tag_i]));
  assert_result_marks_done_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_i && !flush_o) |=> done_q[$past(res_tag_i)]);
  assert_exc_flush_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_o |-> (flush_o && !rf_we_o && !st_we_o));
  assert_flush_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_o |=> !flush_o);
  assert_fire_empty_ok_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (empty && disp_valid_i && disp_rs_free_i && !flush_o) |-> disp_fire_o);
endmodule

// File: tb/sim_rob_core.sv
module sim_rob_core;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  logic        disp_valid = 0, disp_rs_free = 0, disp_wr = 0;
  logic [1:0]  disp_kind = 0;
  logic [3:0]  disp_dst = 0;
  logic        disp_fire;
  logic [2:0]  disp_tag;
  logic        res_valid = 0, res_exc = 0, res_mis = 0;
  logic [2:0]  res_tag = 0;
  logic [31:0] res_value = 0, res_target = 0;
  logic [3:0]  lk_reg = 0;
  logic        lk_busy, lk_ready;
  logic [2:0]  lk_tag;
  logic [31:0] lk_value;
  logic        rf_we, st_we, exc, flush;
  logic [3:0]  rf_addr;
  logic [31:0] rf_data, st_data, redirect_pc;

  rob_core u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .disp_valid_i(disp_valid), .disp_rs_free_i(disp_rs_free), .disp_kind_i(disp_kind),
    .disp_dst_i(disp_dst), .disp_wr_i(disp_wr), .disp_fire_o(disp_fire), .disp_tag_o(disp_tag),
    .res_valid_i(res_valid), .res_tag_i(res_tag), .res_value_i(res_value), .res_exc_i(res_exc),
    .res_mispred_i(res_mis), .res_target_i(res_target),
    .lk_reg_i(lk_reg), .lk_busy_o(lk_busy), .lk_ready_o(lk_ready), .lk_tag_o(lk_tag),
    .lk_value_o(lk_value),
    .rf_we_o(rf_we), .rf_addr_o(rf_addr), .rf_data_o(rf_data),
    .st_we_o(st_we), .st_data_o(st_data), .exc_o(exc), .flush_o(flush),
    .redirect_pc_o(redirect_pc)
  );

  typedef struct { int kind; int addr; logic [31:0] data; } ev_t; // kind: 0 rf, 1 st, 2 exc, 3 redirect
  ev_t exp_q[$];
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, expv);
    end
  endtask

  task automatic expect_ev(input int k, input int a, input logic [31:0] d);
    ev_t e;
    e.kind = k; e.addr = a; e.data = d;
    exp_q.push_back(e);
  endtask

  // monitor: every retirement event must match the scoreboard head
  always @(negedge clk) begin
    if (rst_n && (rf_we || st_we || flush)) begin
      int k;
      k = flush ? (exc ? 2 : 3) : (rf_we ? 0 : 1);
      if (exp_q.size() == 0) chk(0, "R4", "unexpected retirement kind", k, 0);
      else begin
        ev_t e;
        e = exp_q.pop_front();
        chk(k == e.kind, "R4", "retirement kind", k, e.kind);
        if (e.kind == 0) begin
          chk(rf_addr == e.addr[3:0], "R5", "rf address", rf_addr, e.addr);
          chk(rf_data == e.data, "R5", "rf data", rf_data, e.data);
        end else if (e.kind == 1) chk(st_data == e.data, "R6", "store data", st_data, e.data);
        else if (e.kind == 2) chk(exc && !rf_we, "R7", "exception raised", exc, 1);
        else chk(redirect_pc == e.data, "R8", "redirect pc", redirect_pc, e.data);
      end
    end
  end

  task automatic dispatch(input logic [1:0] k, input logic [3:0] d, input logic w,
                          output logic [2:0] t);
    disp_valid = 1; disp_rs_free = 1; disp_kind = k; disp_dst = d; disp_wr = w;
    @(negedge clk);
    t = disp_tag;
    chk(disp_fire === 1'b1, "R1", "dispatch accepted", disp_fire, 1);
    @(posedge clk); #1;
    disp_valid = 0;
  endtask

  task automatic result(input logic [2:0] t, input logic [31:0] v, input logic e,
                        input logic m, input logic [31:0] tg);
    res_valid = 1; res_tag = t; res_value = v; res_exc = e; res_mis = m; res_target = tg;
    @(posedge clk); #1;
    res_valid = 0; res_exc = 0; res_mis = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=%h expected=%h", 0, 1);
    finish_run();
  end

  initial begin
    logic [2:0] ta, tb, tc, td;
    logic [2:0] tf [8];
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    lk_reg = 3;
    #1;
    chk(disp_fire == 0 && rf_we == 0 && st_we == 0 && flush == 0, "R1", "reset quiet", disp_fire, 0);
    chk(lk_busy == 0, "R9", "reset map empty", lk_busy, 0);
    @(posedge clk); #1;

    // in-order retirement with out-of-order results
    dispatch(0, 3, 1, ta);
    dispatch(0, 5, 1, tb);
    dispatch(1, 0, 0, tc);
    dispatch(0, 3, 1, td);
    chk({ta, tb, tc, td} == {3'd0, 3'd1, 3'd2, 3'd3}, "R1", "tags in order", {ta, tb, tc, td}, 12'h053);
    lk_reg = 3; #1;
    chk(lk_busy && lk_tag == td, "R9", "youngest writer mapped", lk_tag, td);
    expect_ev(0, 3, 32'h11);
    expect_ev(0, 5, 32'h55);
    expect_ev(1, 0, 32'h22);
    expect_ev(0, 3, 32'h33);
    result(tb, 32'h55, 0, 0, 0);
    lk_reg = 5;
    @(negedge clk);
    chk(rf_we == 0 && st_we == 0, "R4", "younger done slot held", rf_we, 0);
    chk(lk_ready && lk_value == 32'h55, "R3", "lookup value", lk_value, 32'h55);
    @(posedge clk); #1;
    result(td, 32'h33, 0, 0, 0);
    result(tc, 32'h22, 0, 0, 0);
    result(ta, 32'h11, 0, 0, 0);
    @(posedge clk); #1;
    lk_reg = 3; #1;
    chk(lk_busy && lk_tag == td, "R9", "older retire keeps map", lk_tag, td);
    idle(5);
    chk(lk_busy == 0, "R9", "map cleared after writer retires", lk_busy, 0);

    // refused dispatch: no reservation station
    disp_valid = 1; disp_rs_free = 0;
    @(negedge clk);
    chk(disp_fire == 0, "R1", "no station stalls", disp_fire, 0);
    @(posedge clk); #1;
    disp_valid = 0;

    // fill to capacity
    for (int i = 0; i < 8; i++) dispatch(0, 4'(i), 0, tf[i]);
    chk(tf[0] == 3'd4 && tf[7] == 3'd3, "R1", "tags wrap", tf[7], 3);
    disp_valid = 1; disp_rs_free = 1;
    @(negedge clk);
    chk(disp_fire == 0, "R2", "full stalls", disp_fire, 0);
    @(posedge clk); #1;
    disp_valid = 0;
    for (int i = 0; i < 8; i++) result(tf[i], 32'(i), 0, 0, 0);
    idle(3);

    // exception at retirement discards younger slot
    dispatch(0, 7, 1, ta);
    dispatch(0, 8, 1, tb);
    expect_ev(2, 0, 0);
    result(tb, 32'h9, 0, 0, 0);
    result(ta, 32'h0, 1, 0, 0);
    @(posedge clk); #1;
    lk_reg = 8; #1;
    chk(lk_busy == 0, "R7", "younger writer discarded", lk_busy, 0);
    idle(3);

    // mispredicted branch
    dispatch(2, 0, 0, ta);
    dispatch(0, 9, 1, tb);
    expect_ev(3, 0, 32'h400);
    result(tb, 32'h99, 0, 0, 0);
    result(ta, 32'h0, 0, 1, 32'h400);
    @(posedge clk); #1;
    lk_reg = 9; #1;
    chk(lk_busy == 0, "R8", "map cleared by flush", lk_busy, 0);
    chk(flush == 0, "R8", "flush one cycle", flush, 0);
    idle(3);

    // correctly predicted branch retires silently
    dispatch(2, 0, 0, ta);
    dispatch(0, 2, 1, tb);
    expect_ev(0, 2, 32'h77);
    result(tb, 32'h77, 0, 0, 0);
    result(ta, 32'h0, 0, 0, 32'h800);
    idle(5);
    chk(exp_q.size() == 0, "R4", "all expected retirements seen", exp_q.size(), 0);
    finish_run();
  end
endmodule